// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a small register-mapped timer that marks off fixed periods of the system clock. A prescaler divides the clock by sixteen. Each prescaler tick advances a 20-bit current count. When the current count reaches the programmed interval, it returns to zero, a period-complete flag is raised and a 12-bit count of completed periods goes up by one. Software programs the interval and the two enable bits through a mode word. It learns about elapsed time by reading one packed word that holds the period count and the current count.

The packed word can be read at two addresses. A read at the acknowledging address clears the flag and the period count. A read at the image address changes nothing, so software can sample the running time freely. A level interrupt is driven while the flag is set and the interrupt enable is on. When the timer enable is cleared, the timer does not stop at once. It finishes the period in progress, returns to zero and then halts.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, the mode word (offset 0x00), the status word (offset 0x04) and the image word (offset 0x0C) all read zero, and `irq` is low.
- R2: While the timer runs, the current count (bits 19:0 of the packed word) advances once every 16 clock cycles. With interval value N in mode bits 19:0, the count steps 0, 1, … N and then returns to 0, so a period lasts N+1 counts.
- R3: Each return of the current count to zero sets status bit 0 and raises the period count (bits 31:20 of the packed word) by one.
- R4: A read at offset 0x08 returns the packed word. On the clock edge of that read, the status flag and the period count are cleared.
- R5: A read at offset 0x0C returns the same packed word. It leaves the flag, the period count and the current count unchanged.
- R6: `irq` is high exactly while status bit 0 is set and mode bit 25 (interrupt enable) is 1.
- R7: When mode bit 24 (timer enable) is cleared mid-period, counting continues until the current count returns to zero. That return still sets the flag. After it, the count stays at zero.
- R8: A period may complete on the same edge as a read at 0x08. In that case the read returns the old word, the flag stays set and the period count becomes 1.
- R9: After period count 4095, the next completed period makes it 0. The flag remains set.
- R10: The mode word stores only bits 25, 24 and 19:0, and every other bit reads zero. Writes to offsets 0x04, 0x08 and 0x0C change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a prescale of 16, a 20-bit interval and a 12-bit period count. These are the values whose cycle counts the requirements quote. Interval value zero gives the shortest period, 16 clocks. At that rate, 4096 periods fit in about 65,000 cycles, which brings the period-count rollover within reach. Small interval values let the bench place an acknowledging read on exactly the edge where a period ends. They also let it place the clearing of the enable in the middle of a period and watch the drain.

// File: rtl/itt_pkg.sv
package itt_pkg;

    // Byte offsets decoded by the register bank
    localparam int unsigned OFF_MODE  = 32'h0;
    localparam int unsigned OFF_STAT  = 32'h4;
    localparam int unsigned OFF_VALUE = 32'h8;
    localparam int unsigned OFF_IMAGE = 32'hC;

    // Bit positions in the mode word
    localparam int unsigned IRQ_EN_BIT = 25;
    localparam int unsigned RUN_EN_BIT = 24;

    // Bit position of the flag in the status word
    localparam int unsigned FLAG_BIT = 0;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [2:0] {
        SEL_MODE,
        SEL_STAT,
        SEL_VALUE,
        SEL_IMAGE,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/itt_prescaler.sv
module itt_prescaler #(
    parameter int unsigned PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign tick = run && (st_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: two ticks never come on back-to-back cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/itt_counter.sv
module itt_counter #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    input  logic             ack,
    output logic [CNT_W-1:0] cur,
    output logic [PER_W-1:0] periods,
    output logic             flag,
    output logic             run
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic [PER_W-1:0] periods;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wrap;

    // Keep running after the enable drops until the count is back at zero
    assign run  = enable || (st_q.cur != '0);
    // A count at or past the interval ends the period, even after a reprogram
    assign wrap = tick && (st_q.cur >= interval);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cur = wrap ? '0 : st_q.cur + 1'b1;
        end
        if (ack) begin
            st_d.flag    = wrap;
            st_d.periods = wrap ? PER_W'(1) : '0;
        end else if (wrap) begin
            st_d.flag    = 1'b1;
            st_d.periods = st_q.periods + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur     = st_q.cur;
    assign periods = st_q.periods;
    assign flag    = st_q.flag;

    // R2: the count changes only on a prescaler tick
    a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cur));

    // R3: a completed period leaves the flag set
    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.flag);

    // R4: an acknowledge with no new period clears flag and count
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (!st_q.flag && st_q.periods == '0));

    // R7: stopped at zero means staying at zero
    a_r7_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && st_q.cur == '0) |=> (st_q.cur == '0));

    // R8: a period ending on the acknowledge edge is kept
    a_r8_ack_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (st_q.flag && st_q.periods == PER_W'(1)));

    // R9: the period count rolls over from all ones to zero
    a_r9_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ack && (&st_q.periods)) |=> (st_q.periods == '0));

endmodule

// File: rtl/itt_regs.sv
module itt_regs
    import itt_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cur,
    input  logic [PER_W-1:0]  periods,
    input  logic              flag,
    output logic              enable,
    output logic              irq_en,
    output logic [CNT_W-1:0]  interval,
    output logic              ack
);

    typedef struct packed {
        logic             irq_en;
        logic             enable;
        logic [CNT_W-1:0] interval;
    } mode_t;

    mode_t      mode_d, mode_q;
    reg_sel_e   sel;
    logic       mode_wr;
    logic       rd;
    logic [BUS_W-1:0] word;
    logic       unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_MODE)) begin
            sel = SEL_MODE;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            sel = SEL_STAT;
        end else if (bus_addr == ADDR_W'(OFF_VALUE)) begin
            sel = SEL_VALUE;
        end else if (bus_addr == ADDR_W'(OFF_IMAGE)) begin
            sel = SEL_IMAGE;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign mode_wr = bus_sel && bus_wr && (sel == SEL_MODE);
    assign rd      = bus_sel && !bus_wr;
    assign ack     = rd && (sel == SEL_VALUE);

    always_comb begin
        mode_d = mode_q;
        if (mode_wr) begin
            mode_d.irq_en   = bus_wdata[IRQ_EN_BIT];
            mode_d.enable   = bus_wdata[RUN_EN_BIT];
            mode_d.interval = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        word = '0;
        unique case (sel)
            SEL_MODE: begin
                word[IRQ_EN_BIT]  = mode_q.irq_en;
                word[RUN_EN_BIT]  = mode_q.enable;
                word[CNT_W-1:0]   = mode_q.interval;
            end
            SEL_STAT: begin
                word[FLAG_BIT] = flag;
            end
            SEL_VALUE, SEL_IMAGE: begin
                word[CNT_W +: PER_W] = periods;
                word[CNT_W-1:0]      = cur;
            end
            default: begin
                word = '0;
            end
        endcase
    end

    assign bus_rdata = rd ? word : '0;
    assign enable    = mode_q.enable;
    assign irq_en    = mode_q.irq_en;
    assign interval  = mode_q.interval;

    // R10: the mode word changes only through a write at its own offset
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));

    // R4: an acknowledge never comes from a write
    a_r4_ack_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !bus_wr);

endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer
    import itt_pkg::*;
#(
    parameter int unsigned PRESCALE = 16,
    parameter int unsigned CNT_W    = 20,
    parameter int unsigned PER_W    = 12,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    logic             enable;
    logic             irq_en;
    logic [CNT_W-1:0] interval;
    logic             ack;
    logic [CNT_W-1:0] cur;
    logic [PER_W-1:0] periods;
    logic             flag;
    logic             run;
    logic             tick;

    itt_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PER_W  (PER_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur       (cur),
        .periods   (periods),
        .flag      (flag),
        .enable    (enable),
        .irq_en    (irq_en),
        .interval  (interval),
        .ack       (ack)
    );

    itt_prescaler #(
        .PRESCALE (PRESCALE)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    itt_counter #(
        .CNT_W (CNT_W),
        .PER_W (PER_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .interval (interval),
        .ack      (ack),
        .cur      (cur),
        .periods  (periods),
        .flag     (flag),
        .run      (run)
    );

    assign irq = flag && irq_en;

    // R6: after an acknowledge with no new period, the interrupt is low
    a_r6_irq_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick) |=> !irq);

endmodule

// File: tb/interval_tick_timer_tb_top.sv
`timescale 1ns/1ps
module interval_tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_MODE = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_VAL  = 4'h8;
    localparam logic [3:0] A_IMG  = 4'hC;
    localparam logic [31:0] EN    = 32'h0100_0000;
    localparam logic [31:0] IEN   = 32'h0200_0000;

    always #10 clk = ~clk;

    interval_tick_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        bus_sel   = 1'b1;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    // Mid-cycle read that is withdrawn before the next edge
    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_wr   = 1'b0;
        bus_sel  = 1'b1;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ack_read(output logic [31:0] d);
        @(negedge clk);
        bus_addr = A_VAL;
        bus_wr   = 1'b0;
        bus_sel  = 1'b1;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic after_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        apply_reset();
        after_edges(1);
        peek(A_MODE, d); check("R1 mode", d, 32'h0);
        peek(A_STAT, d); check("R1 status", d, 32'h0);
        peek(A_IMG, d);  check("R1 image", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_period_timing();
        logic [31:0] d;
        apply_reset();
        bus_write(A_MODE, EN | 32'd2);
        after_edges(47);
        peek(A_IMG, d);  check("R2 count before wrap", d, 32'h0000_0002);
        peek(A_STAT, d); check("R3 flag before wrap", d, 32'h0);
        after_edges(1);
        peek(A_IMG, d);  check("R3 image after wrap", d, 32'h0010_0000);
        peek(A_STAT, d); check("R3 flag after wrap", d, 32'h1);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        bus_write(A_MODE, EN | IEN | 32'd2);
        check("R6 irq enabled", {31'b0, irq}, 32'h1);
        peek(A_IMG, d);  check("R5 image read", d, 32'h0010_0000);
        peek(A_STAT, d); check("R5 flag kept", d, 32'h1);
        ack_read(d);     check("R4 value word", d, 32'h0010_0000);
        peek(A_STAT, d); check("R4 flag cleared", d, 32'h0);
        peek(A_IMG, d);  check("R4 count cleared", d, 32'h0);
        check("R6 irq after ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_accumulate();
        logic [31:0] d;
        logic [31:0] first;
        apply_reset();
        bus_write(A_MODE, EN | 32'd1);
        after_edges(90);
        peek(A_IMG, first); check("R3 two periods", first, 32'h0020_0001);
        peek(A_IMG, d);     check("R5 repeat image", d, first);
        peek(A_STAT, d);    check("R5 flag after images", d, 32'h1);
        ack_read(d);        check("R4 accumulated word", d, 32'h0020_0001);
        peek(A_IMG, d);     check("R4 image after ack", d, 32'h0000_0001);
        peek(A_STAT, d);    check("R4 status after ack", d, 32'h0);
    endtask

    task automatic t_graceful_stop();
        logic [31:0] d;
        apply_reset();
        bus_write(A_MODE, EN | 32'd3);
        after_edges(20);
        bus_write(A_MODE, 32'd3);
        peek(A_MODE, d); check("R7 enable cleared", d, 32'h0000_0003);
        after_edges(42);
        peek(A_IMG, d);  check("R7 still draining", d, 32'h0000_0003);
        peek(A_STAT, d); check("R7 no flag yet", d, 32'h0);
        after_edges(1);
        peek(A_IMG, d);  check("R7 final wrap", d, 32'h0010_0000);
        peek(A_STAT, d); check("R7 flag on final wrap", d, 32'h1);
        after_edges(40);
        peek(A_IMG, d);  check("R7 halted", d, 32'h0010_0000);
    endtask

    task automatic t_ack_collision();
        logic [31:0] d;
        apply_reset();
        bus_write(A_MODE, EN | 32'd0);
        after_edges(31);
        ack_read(d);     check("R8 word read", d, 32'h0010_0000);
        peek(A_STAT, d); check("R8 flag kept", d, 32'h1);
        peek(A_IMG, d);  check("R8 count is one", d, 32'h0010_0000);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d;
        apply_reset();
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(A_VAL,  32'hFFFF_FFFF);
        bus_write(A_IMG,  32'hFFFF_FFFF);
        peek(A_STAT, d); check("R10 status write ignored", d, 32'h0);
        peek(A_IMG, d);  check("R10 value/image write ignored", d, 32'h0);
        peek(A_MODE, d); check("R10 mode untouched", d, 32'h0);
        bus_write(A_MODE, 32'hFCF0_0000);
        peek(A_MODE, d); check("R10 unused bits dropped", d, 32'h0);
        bus_write(A_MODE, 32'hFFFF_FFFF);
        peek(A_MODE, d); check("R10 mode bits kept", d, 32'h030F_FFFF);
    endtask

    task automatic t_rollover();
        logic [31:0] d;
        apply_reset();
        bus_write(A_MODE, EN | 32'd0);
        after_edges(16 * 4095);
        peek(A_IMG, d);  check("R9 count at max", d, 32'hFFF0_0000);
        after_edges(16);
        peek(A_IMG, d);  check("R9 count rolled to zero", d, 32'h0);
        peek(A_STAT, d); check("R9 flag kept", d, 32'h1);
    endtask

    initial begin
        t_reset_state();
        t_period_timing();
        t_accumulate();
        t_graceful_stop();
        t_ack_collision();
        t_ignored_writes();
        t_rollover();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule